// File: doc/BRIEF.md
# Programmable-Frame Serial Master with Register Port

This block is a synchronous serial master driven through a small word-addressed register port. Software fills a transmit queue through a data port. It chooses the frame length, clock idle level, sampling phase and per-direction bit order, and it sets the enable bit. The engine then shifts each queued word out on the data-out pin. For every word it sends, it collects one word from the data-in pin into a receive queue, which software drains through the same data port.

The serial clock comes from the bus clock through two cascaded dividers: an even prescaler and a second stage that divides by one plus a rate value. Chip select, DMA and interrupts are handled outside the block.

Top module: `spi_master_regs`

## Requirements
- R1: Register offsets are fixed. 0x00 is frame setup: [4:0] word size minus one, bit 6 clock idle level, bit 7 phase, [15:8] rate value S. 0x04 is run control: bit 1 enable, bit 4 receive LSB-first, bit 5 transmit LSB-first. 0x08 is the data port. 0x0C is status. 0x10 is the prescaler P in [7:0]. Unlisted bits read zero, and every register resets to zero.
- R2: Status bit 1 reads 1 while the transmit queue is not full. Bit 2 reads 1 while the receive queue holds data. Bit 4 is busy. After reset, status reads 0x02.
- R3: Each serial clock half period lasts (P/2)*(1+S) bus clocks, for even P from 2 to 254. A frame of N bits has exactly 2N clock edges. Between frames the clock rests at the idle level from bit 6.
- R4: The word size N is the size code plus one, from 4 to 32 bits. Only the low N bits of a written word go out. A received word reads zero above bit N-1.
- R5: With transmit LSB-first set, bit 0 is sent first; otherwise bit N-1 is sent first. With receive LSB-first set, the first received bit lands in bit 0; otherwise it lands in bit N-1.
- R6: With phase 0, each data bit is valid before the leading clock edge, and the block samples on that edge. With phase 1, data changes on the leading edge and is sampled on the trailing edge.
- R7: Every transmitted frame places exactly one word in the receive queue.
- R8: Words written while enable is clear wait in the queue and are not shifted. Once enable is set, they go out in write order.
- R9: Each queue holds 8 words. A data-port write to a full transmit queue is dropped. A data-port read of an empty receive queue returns zero.
- R10: Busy is 1 while the transmit queue holds a word or a frame is shifting. It falls after the last edge of the last frame.
- R11: Clearing enable during a frame lets that frame finish, then stops. The clock holds its idle level, and the remaining queued words stay queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive queue at the data port) |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The bench loops data-out back to data-in, sometimes inverted, and rebuilds each frame independently from the pin edges, so a swapped phase or bit order shows up as a reversed or shifted word. It also measures the clock half period and counts edges, which catches a divider that is off by one stage or a frame that is one bit short. Directed cases target queueing while disabled (a design that ignored enable would shift early), overfill and empty reads (a wrap error would corrupt order or return stale data), and disabling mid-frame (a design that stopped at once would leave a truncated word and a clock stuck at the active level).

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
    localparam int WORD_W = 32;
    localparam int SZ_W   = $clog2(WORD_W);
    localparam int REG_AW = 5;

    localparam logic [REG_AW-1:0] OFF_FRAME = 5'h00;
    localparam logic [REG_AW-1:0] OFF_RUN   = 5'h04;
    localparam logic [REG_AW-1:0] OFF_PORT  = 5'h08;
    localparam logic [REG_AW-1:0] OFF_STAT  = 5'h0C;
    localparam logic [REG_AW-1:0] OFF_DIV   = 5'h10;

    typedef struct packed {
        logic [7:0]      rate;
        logic            pha;
        logic            pol;
        logic [SZ_W-1:0] size_m1;
    } frame_cfg_t;

    typedef struct packed {
        logic rx_lsb;
        logic tx_lsb;
        logic en;
    } run_cfg_t;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] inc_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CW'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        if (do_push) st_d.wp = inc_ptr(st_q.wp);
        if (do_pop)  st_d.rp = inc_ptr(st_q.rp);
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wp] <= wdata;
    end

    assign rdata = mem_q[st_q.rp];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign level = st_q.cnt;
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [7:0] pre_div,
    input  logic [7:0] post_div,
    output logic       tick
);
    typedef struct packed {
        logic [6:0] pre;
        logic [7:0] post;
    } rate_st_t;

    rate_st_t st_d, st_q;
    logic [6:0] pre_last;
    logic       pre_wrap;

    // Half a serial period: (P/2) bus clocks per stage-one step, (1+S) steps
    always_comb begin
        pre_last = (pre_div[7:1] == 7'd0) ? 7'd0 : pre_div[7:1] - 7'd1;
        pre_wrap = (st_q.pre == pre_last);
        tick     = run && pre_wrap && (st_q.post == post_div);
        st_d     = st_q;
        if (!run) begin
            st_d = '0;
        end else if (pre_wrap) begin
            st_d.pre  = '0;
            st_d.post = (st_q.post == post_div) ? 8'd0 : st_q.post + 8'd1;
        end else begin
            st_d.pre = st_q.pre + 7'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_master_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  frame_cfg_t        fcfg,
    input  logic              tx_lsb,
    input  logic              rx_lsb,
    input  logic              tx_empty,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_word,
    input  logic              tick,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              active
);
    localparam int EW = SZ_W + 1;

    typedef struct packed {
        logic              act;
        logic              tog;
        logic [EW-1:0]     edges;
        logic [SZ_W-1:0]   bitn;
        logic [WORD_W-1:0] txw;
        logic [WORD_W-1:0] rxw;
    } eng_st_t;

    eng_st_t st_d, st_q;
    logic [SZ_W-1:0] last_bit, tx_idx, rx_idx;
    logic            leading;

    always_comb begin
        last_bit = (fcfg.size_m1 < SZ_W'(3)) ? SZ_W'(3) : fcfg.size_m1;
        tx_idx   = tx_lsb ? st_q.bitn : last_bit - st_q.bitn;
        rx_idx   = rx_lsb ? st_q.bitn : last_bit - st_q.bitn;
        leading  = !st_q.edges[0];
        st_d     = st_q;
        tx_pop   = 1'b0;
        rx_push  = 1'b0;
        if (!st_q.act) begin
            if (enable && !tx_empty) begin
                st_d.act   = 1'b1;
                st_d.tog   = 1'b0;
                st_d.edges = '0;
                st_d.bitn  = '0;
                st_d.txw   = tx_word;
                st_d.rxw   = '0;
                tx_pop     = 1'b1;
            end
        end else if (tick) begin
            st_d.tog   = ~st_q.tog;
            st_d.edges = st_q.edges + 1'b1;
            if (leading) begin
                if (!fcfg.pha)                st_d.rxw[rx_idx] = miso;
                else if (st_q.edges != '0)    st_d.bitn = st_q.bitn + 1'b1;
            end else begin
                if (fcfg.pha)                 st_d.rxw[rx_idx] = miso;
                if (st_q.bitn == last_bit) begin
                    st_d.act = 1'b0;
                    rx_push  = 1'b1;
                end else if (!fcfg.pha) begin
                    st_d.bitn = st_q.bitn + 1'b1;
                end
            end
        end
        rx_word = st_d.rxw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mosi   = st_q.act ? st_q.txw[tx_idx] : 1'b0;
    assign sclk   = fcfg.pol ^ st_q.tog;
    assign active = st_q.act;
endmodule

// File: rtl/spi_master_regs.sv
module spi_master_regs
    import spi_master_pkg::*;
#(
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i
);
    localparam int LVL_W = $clog2(FIFO_DEPTH+1);

    typedef struct packed {
        frame_cfg_t fcfg;
        run_cfg_t   run;
        logic [7:0] div;
    } regs_t;

    regs_t regs_d, regs_q;

    logic              tx_push, tx_pop, tx_empty, tx_full;
    logic              rx_push, rx_pop, rx_empty, rx_full;
    logic [WORD_W-1:0] tx_head, rx_head, rx_new;
    logic [LVL_W-1:0]  tx_level, rx_level;
    logic              tick, shift_act, busy;

    always_comb begin
        regs_d  = regs_q;
        tx_push = reg_wr && (reg_addr == OFF_PORT);
        rx_pop  = reg_rd && (reg_addr == OFF_PORT);
        if (reg_wr) begin
            case (reg_addr)
                OFF_FRAME: regs_d.fcfg = {reg_wdata[15:8], reg_wdata[7], reg_wdata[6], reg_wdata[SZ_W-1:0]};
                OFF_RUN:   regs_d.run  = {reg_wdata[4], reg_wdata[5], reg_wdata[1]};
                OFF_DIV:   regs_d.div  = reg_wdata[7:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign busy = !tx_empty || shift_act;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_FRAME: reg_rdata = {16'd0, regs_q.fcfg.rate, regs_q.fcfg.pha, regs_q.fcfg.pol,
                                    1'b0, regs_q.fcfg.size_m1};
            OFF_RUN:   reg_rdata = {26'd0, regs_q.run.tx_lsb, regs_q.run.rx_lsb, 2'b00,
                                    regs_q.run.en, 1'b0};
            OFF_PORT:  reg_rdata = rx_empty ? 32'd0 : rx_head;
            OFF_STAT:  reg_rdata = {27'd0, busy, 1'b0, !rx_empty, !tx_full, 1'b0};
            OFF_DIV:   reg_rdata = {24'd0, regs_q.div};
            default:   reg_rdata = '0;
        endcase
    end

    spi_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(reg_wdata), .pop(tx_pop),
        .rdata(tx_head), .empty(tx_empty), .full(tx_full), .level(tx_level)
    );

    spi_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_new), .pop(rx_pop),
        .rdata(rx_head), .empty(rx_empty), .full(rx_full), .level(rx_level)
    );

    spi_rate_gen u_rate (
        .clk(clk), .rst_n(rst_n), .run(shift_act), .pre_div(regs_q.div),
        .post_div(regs_q.fcfg.rate), .tick(tick)
    );

    spi_shift_engine u_shift (
        .clk(clk), .rst_n(rst_n), .enable(regs_q.run.en), .fcfg(regs_q.fcfg),
        .tx_lsb(regs_q.run.tx_lsb), .rx_lsb(regs_q.run.rx_lsb),
        .tx_empty(tx_empty), .tx_word(tx_head), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_word(rx_new), .tick(tick), .miso(miso_i),
        .sclk(sclk_o), .mosi(mosi_o), .active(shift_act)
    );
endmodule

// File: rtl/spi_master_regs_chk.sv
module spi_master_regs_chk #(
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       busy,
    input logic                       shift_act,
    input logic                       cfg_en,
    input logic                       cfg_pol,
    input logic                       sclk_o,
    input logic [$clog2(DEPTH+1)-1:0] tx_level,
    input logic [$clog2(DEPTH+1)-1:0] rx_level
);
    AST_TX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= ($clog2(DEPTH+1))'(DEPTH)); // R9
    AST_RX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level <= ($clog2(DEPTH+1))'(DEPTH)); // R9
    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && !shift_act) |=> !shift_act); // R8
    AST_BUSY_COVERS_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level != '0) |-> busy); // R10
    AST_BUSY_FALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (tx_level == '0 && !shift_act)); // R10
    AST_SCLK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_act |-> (sclk_o == cfg_pol)); // R3
endmodule

bind spi_master_regs spi_master_regs_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .shift_act(shift_act),
    .cfg_en(regs_q.run.en), .cfg_pol(regs_q.fcfg.pol), .sclk_o(sclk_o),
    .tx_level(tx_level), .rx_level(rx_level)
);

// File: tb/spi_master_regs_bench.sv
module spi_master_regs_bench;
    typedef struct packed {
        logic [4:0]  code;
        logic        pol;
        logic        pha;
        logic        rxl;
        logic        txl;
        logic        inv;
        logic [7:0]  pdiv;
        logic [7:0]  rate;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{5'd7,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2,  8'd0, 32'h0000_00A5},
        '{5'd15, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd4,  8'd1, 32'hFFFF_1234},
        '{5'd3,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'd6,  8'd2, 32'h0000_000B},
        '{5'd31, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'd2,  8'd3, 32'h1234_5678},
        '{5'd11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd8,  8'd0, 32'hFEDC_BABC},
        '{5'd4,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'd10, 8'd0, 32'h0000_0035}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sclk_o, mosi_o, miso_i;
    logic        tb_inv = 1'b0, tb_pol = 1'b0, tb_pha = 1'b0;

    int checks = 0, fails = 0;
    bit done = 0;

    int          mon_edges;
    logic [31:0] mon_cap;
    longint      mon_last, mon_hmin, mon_hmax;

    always #2 clk = ~clk;
    assign miso_i = mosi_o ^ tb_inv;

    spi_master_regs u_spi_master_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk_o(sclk_o), .mosi_o(mosi_o),
        .miso_i(miso_i)
    );

    // Independent pin monitor: counts edges, measures half periods, rebuilds the word
    always @(sclk_o) begin
        if (mon_edges > 0) begin
            if ($time - mon_last < mon_hmin) mon_hmin = $time - mon_last;
            if ($time - mon_last > mon_hmax) mon_hmax = $time - mon_last;
        end
        mon_last = $time;
        mon_edges++;
        if ((sclk_o != tb_pol) ^ tb_pha) mon_cap = {mon_cap[30:0], mosi_o};
    end

    task automatic mon_clear();
        mon_edges = 0; mon_cap = '0; mon_hmin = 64'd1 << 40; mon_hmax = 0;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            rd(5'h0C, s);
            if (!s[4]) break;
        end
    endtask

    function automatic logic [31:0] rev_n(input logic [31:0] v, input int n);
        logic [31:0] r = '0;
        for (int i = 0; i < n; i++) r[n-1-i] = v[i];
        return r;
    endfunction

    initial begin
        #800000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        mon_clear();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R3 reset sclk idle", {31'd0, sclk_o}, 32'd0);
        check("R5 reset mosi", {31'd0, mosi_o}, 32'd0);
        rd(5'h00, v); check("R1 frame reset", v, 32'h0);
        rd(5'h04, v); check("R1 run reset", v, 32'h0);
        rd(5'h10, v); check("R1 div reset", v, 32'h0);
        rd(5'h0C, v); check("R2 status reset", v, 32'h2);

        wr(5'h00, 32'hFFFF_FFFF); rd(5'h00, v); check("R1 frame fields", v, 32'h0000_FFDF);
        wr(5'h04, 32'hFFFF_FFFF); rd(5'h04, v); check("R1 run fields", v, 32'h32);
        wr(5'h10, 32'h0000_01FE); rd(5'h10, v); check("R1 div field", v, 32'hFE);
        wr(5'h04, 32'h0); wr(5'h00, 32'h0);

        // Table walk: loopback frames with varied size, mode, order and rate
        for (int k = 0; k < NV; k++) begin
            vec_t t = VECS[k];
            int n = int'(t.code) + 1;
            logic [31:0] mask = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
            logic [31:0] wire_w = t.txl ? rev_n(t.data & mask, n) : (t.data & mask);
            logic [31:0] rx_w = wire_w ^ (t.inv ? mask : 32'd0);
            logic [31:0] exp_rx = t.rxl ? rev_n(rx_w, n) : rx_w;
            int half = (int'(t.pdiv) / 2) * (int'(t.rate) + 1);
            wr(5'h04, 32'h0);
            wr(5'h10, {24'd0, t.pdiv});
            wr(5'h00, {16'd0, t.rate, t.pha, t.pol, 1'b0, t.code});
            tb_pol = t.pol; tb_pha = t.pha; tb_inv = t.inv;
            repeat (2) @(posedge clk);
            mon_clear();
            wr(5'h08, t.data);
            wr(5'h04, {26'd0, t.txl, t.rxl, 2'b00, 1'b1, 1'b0});
            wait_idle();
            rd(5'h0C, v);   check("R7 one word received", v & 32'h4, 32'h4);
            rd(5'h08, v);   check("R4/R5 received word", v, exp_rx);
            check("R5/R6 wire bits", mon_cap, wire_w);
            check("R3 edge count", mon_edges, 2 * n);
            check("R3 half period min", 32'(mon_hmin), 32'(half * 4));
            check("R3 half period max", 32'(mon_hmax), 32'(half * 4));
        end

        // R8: preload while disabled
        wr(5'h04, 32'h0); wr(5'h10, 32'd2); wr(5'h00, 32'h7);
        tb_pol = 0; tb_pha = 0; tb_inv = 0;
        repeat (2) @(posedge clk); mon_clear();
        wr(5'h08, 32'h11); wr(5'h08, 32'h22); wr(5'h08, 32'h33);
        repeat (20) @(posedge clk);
        rd(5'h0C, v); check("R10 busy while queued", v, 32'h12);
        check("R8 no edges while disabled", mon_edges, 0);
        wr(5'h04, 32'h2); wait_idle();
        rd(5'h08, v); check("R8 order 1", v, 32'h11);
        rd(5'h08, v); check("R8 order 2", v, 32'h22);
        rd(5'h08, v); check("R8 order 3", v, 32'h33);
        rd(5'h08, v); check("R9 empty read zero", v, 32'h0);
        rd(5'h0C, v); check("R2 status idle", v, 32'h2);

        // R9: overfill the transmit queue
        wr(5'h04, 32'h0);
        for (int i = 1; i <= 10; i++) wr(5'h08, 32'h40 + i);
        rd(5'h0C, v); check("R9 full flag", v, 32'h10);
        wr(5'h04, 32'h2); wait_idle();
        for (int i = 1; i <= 8; i++) begin
            rd(5'h08, v); check("R9 kept word", v, 32'h40 + i);
        end
        rd(5'h08, v); check("R9 dropped word", v, 32'h0);

        // R11: disable mid-frame
        wr(5'h04, 32'h0); wr(5'h10, 32'd4); wr(5'h00, 32'h0000_014F);
        tb_pol = 1; tb_pha = 0;
        repeat (2) @(posedge clk); mon_clear();
        wr(5'h08, 32'hBEEF); wr(5'h08, 32'hCAFE);
        wr(5'h04, 32'h2);
        repeat (10) @(posedge clk);
        wr(5'h04, 32'h0);
        repeat (300) @(posedge clk);
        rd(5'h0C, v); check("R11 status after stop", v, 32'h16);
        check("R11 sclk idle high", {31'd0, sclk_o}, 32'd1);
        check("R11 frame completed", mon_edges, 32);
        rd(5'h08, v); check("R11 first word", v, 32'hBEEF);
        wr(5'h04, 32'h2); wait_idle();
        rd(5'h08, v); check("R11 second word", v, 32'hCAFE);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule